// File: doc/BRIEF.md
# I2C Transaction Sequencer

This block runs one complete I2C master transaction from a single command by driving a byte-level bus engine. The engine offers a control write, an interrupt-style completion flag, a status byte, a transmit byte and a receive byte. The sequencer supports three transaction kinds:

- **Probe.** Address a chip for reading and throw away one byte.
- **Write.** Send up to four offset bytes, then a stream of payload bytes.
- **Combined read.** Send the offset bytes in write mode, then issue a repeated START, re-address the chip for reading and stream the received bytes out.

After every step the sequencer compares the engine status with the code that step should produce. Each wait is bounded by a count of SCL-period polls. At the end the sequencer returns one 32-bit result word, which is zero on success and otherwise identifies the failure.

Outgoing payload is pulled one byte per `wr_take` pulse from a source that always holds the next byte ready. Incoming bytes are pushed out on `rd_valid` with no back-pressure. Bus pin timing and the SCL divider belong to the engine and sit outside this block.

Top module: `i2c_txn_seq`

## Requirements
- R1: The address byte is `{chip[6:0], dir}`, where dir is 1 for read and 0 for write. Its step expects status 0x40 when dir is 1 and 0x18 when dir is 0.
- R2: A transaction opens with a START step expecting 0x08. Offset bytes follow, least significant first. Offset lengths above 4 are treated as 4. A write then sends its payload bytes, and `wr_take` pulses once per payload byte. Every offset and payload byte step expects 0x28.
- R3: A read sends its offset bytes in write mode, then a repeated START expecting 0x10 with no STOP in between, then the address byte with dir=1.
- R4: In a read, every received byte except the last is acknowledged (control 0x44, expects 0x50). The last byte is not acknowledged (control 0x40, expects 0x58). Each received byte appears on `rd_data` with a one-cycle `rd_valid`.
- R5: A probe (kind 2 or 3) sends the address with dir=1 and then receives one byte without acknowledging it. That byte is never presented on `rd_data`.
- R6: Every transaction ends with a STOP step (control 0x50), which waits for status 0xF8 instead of the flag. The STOP is also issued after a failure. The result is the first failing step's word, or the STOP step's word if no earlier step failed.
- R7: A failure word is `{class, last_control, last_status, expected_status}`, with class 1 for a wrong status and class 2 for a timeout. last_control is the written control value with bit 3 set if the flag was seen. A result of 0 means success.
- R8: A wait polls only on `scl_tick` cycles after the control-write cycle. It times out on the POLL_LIMIT-th poll that does not see completion.
- R9: A command is accepted only while `cmd_ready` is high (idle). `cmd_valid` while busy has no effect. `done` pulses for one cycle with `result`, and `cmd_ready` is high in that same cycle.
- R10: Control bits are: bit 6 enable, bit 5 START, bit 4 STOP, bit 3 flag, bit 2 ACK. Each step writes its control value with exactly one `eng_ctrl_wr` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_ready | output | 1 | Idle, ready for a command |
| cmd_kind | input | 2 | 0 write, 1 read, 2 or 3 probe |
| cmd_chip | input | 7 | 7-bit chip address |
| cmd_offset | input | 32 | Offset bytes, byte 0 sent first |
| cmd_olen | input | 3 | Number of offset bytes (0 to 4) |
| cmd_len | input | 16 | Payload byte count |
| wr_data | input | 8 | Next outgoing payload byte |
| wr_take | output | 1 | Current wr_data is consumed |
| rd_data | output | 8 | Received payload byte |
| rd_valid | output | 1 | rd_data is valid this cycle |
| done | output | 1 | Transaction finished |
| result | output | 32 | Result word, valid with done |
| scl_tick | input | 1 | One pulse per SCL period |
| eng_ctrl_wr | output | 1 | Control write strobe to the engine |
| eng_ctrl | output | 8 | Control value |
| eng_tx | output | 8 | Byte to transmit |
| eng_flag | input | 1 | Engine step-complete flag |
| eng_status | input | 8 | Engine status code |
| eng_rx | input | 8 | Byte received by the engine |

## Verification
The hardest situations to reach are failures in the middle of a transaction: a wrong status on the repeated START of a read, an address byte that is refused during a probe, a wait that never completes partway through the offset bytes, and a STOP that never reaches idle. The bench's engine model derives each status from the bus protocol on its own. Fault knobs then replace or suppress the reply at a chosen control-write index, or withhold the idle status after STOP. The bench also counts the polls of the hung wait, to confirm that exactly POLL_LIMIT polls occur before the STOP write.

// File: rtl/i2c_txn_pkg.sv
`timescale 1ns/1ps
package i2c_txn_pkg;

    typedef enum logic [1:0] {
        KIND_WRITE = 2'd0,
        KIND_READ  = 2'd1,
        KIND_PROBE = 2'd2,
        KIND_PRB2  = 2'd3
    } kind_e;

    // control bit positions
    localparam logic [7:0] CB_ACK   = 8'h04;
    localparam logic [7:0] CB_FLAG  = 8'h08;
    localparam logic [7:0] CB_STOP  = 8'h10;
    localparam logic [7:0] CB_START = 8'h20;
    localparam logic [7:0] CB_EN    = 8'h40;

    // expected status codes
    localparam logic [7:0] ST_START  = 8'h08;
    localparam logic [7:0] ST_RSTART = 8'h10;
    localparam logic [7:0] ST_AW     = 8'h18;
    localparam logic [7:0] ST_DW     = 8'h28;
    localparam logic [7:0] ST_AR     = 8'h40;
    localparam logic [7:0] ST_RACK   = 8'h50;
    localparam logic [7:0] ST_RNAK   = 8'h58;
    localparam logic [7:0] ST_IDLE   = 8'hF8;

    localparam logic [7:0] CLS_WRONG   = 8'h01;
    localparam logic [7:0] CLS_TIMEOUT = 8'h02;

    typedef enum logic [3:0] {
        PH_IDLE, PH_START, PH_ADDR, PH_OFFS, PH_WDATA,
        PH_RSTART, PH_RADDR, PH_RDATA, PH_PRX, PH_STOP
    } phase_e;

    typedef struct packed {
        logic [7:0] ctrl;
        logic [7:0] tx;
        logic [7:0] expect_st;
        logic       stop;
    } step_t;

    function automatic logic [31:0] pack_err(input logic [7:0] cls,
                                             input logic [7:0] ctl,
                                             input logic [7:0] st,
                                             input logic [7:0] ex);
        return {cls, ctl, st, ex};
    endfunction

    function automatic logic [7:0] addr_byte(input logic [6:0] chip, input logic rd);
        return {chip, rd};
    endfunction

endpackage

// File: rtl/i2c_txn_stepgen.sv
`timescale 1ns/1ps
module i2c_txn_stepgen
    import i2c_txn_pkg::*;
#(
    parameter int OFF_BYTES = 4,
    localparam int OLW = $clog2(OFF_BYTES + 1)
) (
    input  phase_e                 phase,
    input  logic [6:0]             chip,
    input  logic                   probe,
    input  logic [OFF_BYTES*8-1:0] offsets,
    input  logic [OLW-1:0]         off_idx,
    input  logic                   last_byte,
    input  logic [7:0]             wr_data,
    output step_t                  step
);
    logic [7:0] off_lane [OFF_BYTES];
    logic [7:0] off_pick;

    for (genvar g = 0; g < OFF_BYTES; g++) begin : g_lane
        assign off_lane[g] = offsets[g*8 +: 8];
    end

    always_comb begin
        off_pick = 8'h00;
        for (int b = 0; b < OFF_BYTES; b++)
            if (off_idx == OLW'(b)) off_pick = off_lane[b];
    end

    always_comb begin
        step = '0;
        case (phase)
            PH_START:  begin step.ctrl = CB_EN | CB_START; step.expect_st = ST_START; end
            PH_RSTART: begin step.ctrl = CB_EN | CB_START; step.expect_st = ST_RSTART; end
            PH_ADDR: begin
                step.ctrl      = CB_EN;
                step.tx        = addr_byte(chip, probe);
                step.expect_st = probe ? ST_AR : ST_AW;
            end
            PH_RADDR: begin
                step.ctrl = CB_EN; step.tx = addr_byte(chip, 1'b1); step.expect_st = ST_AR;
            end
            PH_OFFS:  begin step.ctrl = CB_EN; step.tx = off_pick; step.expect_st = ST_DW; end
            PH_WDATA: begin step.ctrl = CB_EN; step.tx = wr_data;  step.expect_st = ST_DW; end
            PH_RDATA: begin
                step.ctrl      = last_byte ? CB_EN : (CB_EN | CB_ACK);
                step.expect_st = last_byte ? ST_RNAK : ST_RACK;
            end
            PH_PRX:   begin step.ctrl = CB_EN; step.expect_st = ST_RNAK; end
            PH_STOP:  begin
                step.ctrl = CB_EN | CB_STOP; step.expect_st = ST_IDLE; step.stop = 1'b1;
            end
            default:  step = '0;
        endcase
    end
endmodule

// File: rtl/i2c_txn_waiter.sv
`timescale 1ns/1ps
module i2c_txn_waiter
    import i2c_txn_pkg::*;
#(
    parameter int POLL_LIMIT = 1000,
    localparam int CW = $clog2(POLL_LIMIT + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        go,
    input  step_t       go_step,
    output logic        fin,
    output logic [31:0] fin_code,
    output logic [7:0]  fin_rx,
    input  logic        scl_tick,
    output logic        eng_ctrl_wr,
    output logic [7:0]  eng_ctrl,
    output logic [7:0]  eng_tx,
    input  logic        eng_flag,
    input  logic [7:0]  eng_status,
    input  logic [7:0]  eng_rx
);
    step_t          cur;
    logic           polling;
    logic           wr_q;
    logic [CW-1:0]  cnt;
    logic           poll, seen, good, expired;
    logic [7:0]     last_ctl;

    always_comb begin
        poll     = polling && !wr_q && scl_tick;
        seen     = cur.stop ? (eng_status == ST_IDLE) : eng_flag;
        good     = cur.stop || (eng_status == cur.expect_st);
        expired  = (cnt == CW'(POLL_LIMIT - 1));
        last_ctl = cur.ctrl | (eng_flag ? CB_FLAG : 8'h00);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0; polling <= 1'b0; wr_q <= 1'b0; cnt <= '0;
            fin <= 1'b0; fin_code <= '0; fin_rx <= '0;
        end else begin
            wr_q <= 1'b0;
            fin  <= 1'b0;
            if (go && !polling) begin
                cur     <= go_step;
                wr_q    <= 1'b1;
                polling <= 1'b1;
                cnt     <= '0;
            end else if (poll) begin
                if (seen) begin
                    fin      <= 1'b1;
                    polling  <= 1'b0;
                    fin_rx   <= eng_rx;
                    fin_code <= good ? 32'h0
                              : pack_err(CLS_WRONG, last_ctl, eng_status, cur.expect_st);
                end else if (expired) begin
                    fin      <= 1'b1;
                    polling  <= 1'b0;
                    fin_code <= pack_err(CLS_TIMEOUT, last_ctl, eng_status, cur.expect_st);
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign eng_ctrl_wr = wr_q;
    assign eng_ctrl    = cur.ctrl;
    assign eng_tx      = cur.tx;

    p_single_write_r10: assert property (@(posedge clk) disable iff (rst)
        eng_ctrl_wr |=> !eng_ctrl_wr);
    p_class_known_r7: assert property (@(posedge clk) disable iff (rst)
        (fin && fin_code != 32'h0) |-> (fin_code[31:24] == CLS_WRONG || fin_code[31:24] == CLS_TIMEOUT));
    p_wrong_differs_r7: assert property (@(posedge clk) disable iff (rst)
        (fin && fin_code[31:24] == CLS_WRONG) |-> (fin_code[15:8] != fin_code[7:0]));
    p_go_when_free_r8: assert property (@(posedge clk) disable iff (rst)
        go |-> !polling);
endmodule

// File: rtl/i2c_txn_ctrl.sv
`timescale 1ns/1ps
module i2c_txn_ctrl
    import i2c_txn_pkg::*;
#(
    parameter int OFF_BYTES = 4,
    parameter int LEN_W     = 16,
    localparam int OLW = $clog2(OFF_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cmd_valid,
    output logic                   cmd_ready,
    input  logic [1:0]             cmd_kind,
    input  logic [6:0]             cmd_chip,
    input  logic [OFF_BYTES*8-1:0] cmd_offset,
    input  logic [OLW-1:0]         cmd_olen,
    input  logic [LEN_W-1:0]       cmd_len,
    input  logic                   fin,
    input  logic [31:0]            fin_code,
    input  logic [7:0]             fin_rx,
    output phase_e                 phase,
    output logic [6:0]             chip_q,
    output logic                   probe_q,
    output logic [OFF_BYTES*8-1:0] off_q,
    output logic [OLW-1:0]         idx,
    output logic                   last_byte,
    output logic                   go,
    output logic                   wr_take,
    output logic [7:0]             rd_data,
    output logic                   rd_valid,
    output logic                   done,
    output logic [31:0]            result
);
    kind_e           kind_q;
    logic            issue;
    logic [OLW-1:0]  olen_q;
    logic [LEN_W-1:0] len_q, cnt;
    logic [31:0]     err_q;
    logic            err_seen;
    phase_e          ph_after_offs;
    phase_e          ph_after_addr;

    always_comb begin
        last_byte = (cnt == len_q - LEN_W'(1));
        go        = issue && (phase != PH_IDLE);
        wr_take   = go && (phase == PH_WDATA);
        cmd_ready = (phase == PH_IDLE);
        if (kind_q == KIND_READ)     ph_after_offs = PH_RSTART;
        else if (len_q != '0)        ph_after_offs = PH_WDATA;
        else                         ph_after_offs = PH_STOP;
        if (probe_q)                 ph_after_addr = PH_PRX;
        else if (olen_q != '0)       ph_after_addr = PH_OFFS;
        else                         ph_after_addr = ph_after_offs;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE; issue <= 1'b0; kind_q <= KIND_WRITE;
            chip_q <= '0; probe_q <= 1'b0; off_q <= '0; olen_q <= '0;
            len_q <= '0; cnt <= '0; idx <= '0; err_q <= '0; err_seen <= 1'b0;
            rd_data <= '0; rd_valid <= 1'b0; done <= 1'b0; result <= '0;
        end else begin
            done     <= 1'b0;
            rd_valid <= 1'b0;
            if (go) issue <= 1'b0;
            if (phase == PH_IDLE) begin
                if (cmd_valid) begin
                    kind_q   <= kind_e'(cmd_kind);
                    probe_q  <= cmd_kind[1];
                    chip_q   <= cmd_chip;
                    off_q    <= cmd_offset;
                    olen_q   <= (cmd_olen > OLW'(OFF_BYTES)) ? OLW'(OFF_BYTES) : cmd_olen;
                    len_q    <= cmd_len;
                    cnt      <= '0;
                    idx      <= '0;
                    err_seen <= 1'b0;
                    phase    <= PH_START;
                    issue    <= 1'b1;
                end
            end else if (fin) begin
                issue <= 1'b1;
                if (phase == PH_STOP) begin
                    done   <= 1'b1;
                    result <= err_seen ? err_q : fin_code;
                    phase  <= PH_IDLE;
                    issue  <= 1'b0;
                end else if (fin_code != 32'h0) begin
                    err_q    <= fin_code;
                    err_seen <= 1'b1;
                    phase    <= PH_STOP;
                end else begin
                    case (phase)
                        PH_START:  phase <= PH_ADDR;
                        PH_ADDR:   phase <= ph_after_addr;
                        PH_OFFS: begin
                            if (idx == olen_q - OLW'(1)) phase <= ph_after_offs;
                            else idx <= idx + OLW'(1);
                        end
                        PH_WDATA: begin
                            if (last_byte) phase <= PH_STOP;
                            else cnt <= cnt + LEN_W'(1);
                        end
                        PH_RSTART: phase <= PH_RADDR;
                        PH_RADDR:  phase <= (len_q != '0) ? PH_RDATA : PH_STOP;
                        PH_RDATA: begin
                            rd_valid <= 1'b1;
                            rd_data  <= fin_rx;
                            if (last_byte) phase <= PH_STOP;
                            else cnt <= cnt + LEN_W'(1);
                        end
                        PH_PRX:    phase <= PH_STOP;
                        default:   phase <= PH_STOP;
                    endcase
                end
            end
        end
    end

    p_ready_done_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> cmd_ready);
    p_stop_precedes_done_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(phase == PH_STOP));
endmodule

// File: rtl/i2c_txn_seq.sv
`timescale 1ns/1ps
module i2c_txn_seq
    import i2c_txn_pkg::*;
#(
    parameter int OFF_BYTES  = 4,
    parameter int LEN_W      = 16,
    parameter int POLL_LIMIT = 1000,
    localparam int OLW = $clog2(OFF_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cmd_valid,
    output logic                   cmd_ready,
    input  logic [1:0]             cmd_kind,
    input  logic [6:0]             cmd_chip,
    input  logic [OFF_BYTES*8-1:0] cmd_offset,
    input  logic [OLW-1:0]         cmd_olen,
    input  logic [LEN_W-1:0]       cmd_len,
    input  logic [7:0]             wr_data,
    output logic                   wr_take,
    output logic [7:0]             rd_data,
    output logic                   rd_valid,
    output logic                   done,
    output logic [31:0]            result,
    input  logic                   scl_tick,
    output logic                   eng_ctrl_wr,
    output logic [7:0]             eng_ctrl,
    output logic [7:0]             eng_tx,
    input  logic                   eng_flag,
    input  logic [7:0]             eng_status,
    input  logic [7:0]             eng_rx
);
    phase_e                 phase;
    logic [6:0]             chip_q;
    logic                   probe_q;
    logic [OFF_BYTES*8-1:0] off_q;
    logic [OLW-1:0]         idx;
    logic                   last_byte, go, fin;
    logic [31:0]            fin_code;
    logic [7:0]             fin_rx;
    step_t                  step;

    i2c_txn_ctrl #(.OFF_BYTES(OFF_BYTES), .LEN_W(LEN_W)) u_ctrl (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_kind(cmd_kind), .cmd_chip(cmd_chip), .cmd_offset(cmd_offset),
        .cmd_olen(cmd_olen), .cmd_len(cmd_len), .fin(fin), .fin_code(fin_code),
        .fin_rx(fin_rx), .phase(phase), .chip_q(chip_q), .probe_q(probe_q),
        .off_q(off_q), .idx(idx), .last_byte(last_byte), .go(go), .wr_take(wr_take),
        .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .result(result)
    );

    i2c_txn_stepgen #(.OFF_BYTES(OFF_BYTES)) u_stepgen (
        .phase(phase), .chip(chip_q), .probe(probe_q), .offsets(off_q),
        .off_idx(idx), .last_byte(last_byte), .wr_data(wr_data), .step(step)
    );

    i2c_txn_waiter #(.POLL_LIMIT(POLL_LIMIT)) u_waiter (
        .clk(clk), .rst(rst), .go(go), .go_step(step), .fin(fin),
        .fin_code(fin_code), .fin_rx(fin_rx), .scl_tick(scl_tick),
        .eng_ctrl_wr(eng_ctrl_wr), .eng_ctrl(eng_ctrl), .eng_tx(eng_tx),
        .eng_flag(eng_flag), .eng_status(eng_status), .eng_rx(eng_rx)
    );

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> !eng_ctrl_wr);
    p_rx_after_flag_r4: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(eng_flag, 2));
    p_stop_waits_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (eng_ctrl_wr && eng_ctrl[4]) |-> !eng_ctrl[5]);
endmodule

// File: tb/i2c_txn_seq_test.sv
`timescale 1ns/1ps
module i2c_txn_seq_test;
    localparam int LIMIT = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_kind = '0;
    logic [6:0]  cmd_chip = '0;
    logic [31:0] cmd_offset = '0;
    logic [2:0]  cmd_olen = '0;
    logic [15:0] cmd_len = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_take;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        done;
    logic [31:0] result;
    logic        scl_tick = 1'b0;
    logic        eng_ctrl_wr;
    logic [7:0]  eng_ctrl, eng_tx;
    logic        eng_flag = 1'b0;
    logic [7:0]  eng_status = 8'hF8;
    logic [7:0]  eng_rx = '0;

    always #10 clk = ~clk;

    i2c_txn_seq #(.POLL_LIMIT(LIMIT)) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_kind(cmd_kind), .cmd_chip(cmd_chip), .cmd_offset(cmd_offset),
        .cmd_olen(cmd_olen), .cmd_len(cmd_len), .wr_data(wr_data), .wr_take(wr_take),
        .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .result(result),
        .scl_tick(scl_tick), .eng_ctrl_wr(eng_ctrl_wr), .eng_ctrl(eng_ctrl),
        .eng_tx(eng_tx), .eng_flag(eng_flag), .eng_status(eng_status), .eng_rx(eng_rx)
    );

    int checks = 0, fails = 0;
    int q_ctrl[$], q_tx[$], q_exp[$];
    string q_req[$];
    int q_rd[$], rd_at[$], rd_val[$];
    logic [31:0] exp_result = '0;
    bit done_seen = 0;

    // engine model state
    bit in_txn = 0, after_start = 0, rd_dir = 0;
    int pend = 0, reply_st = 0, reply_rx = 0;
    bit reply_flag = 0;
    int wr_index = 0, fault_idx = -1, fault_kind = 0;
    bit stop_hang = 0;
    int rx_base = 8'h90, rx_n = 0, wd_base = 8'h30, wd_n = 0;
    bit bump = 0, hang_live = 0;
    int polls = 0, tick_ctr = 0;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    task automatic engine_write();
        int c;
        c = int'(eng_ctrl);
        eng_flag = 1'b0;
        eng_status = 8'h00;
        reply_flag = 1'b1;
        reply_rx = 0;
        hang_live = 0;
        if ((c & 8'h10) != 0) begin
            reply_st = 8'hF8; reply_flag = 1'b0; in_txn = 0;
        end else if ((c & 8'h20) != 0) begin
            reply_st = in_txn ? 8'h10 : 8'h08; in_txn = 1; after_start = 1;
        end else if (after_start) begin
            reply_st = eng_tx[0] ? 8'h40 : 8'h18; rd_dir = eng_tx[0]; after_start = 0;
        end else if (rd_dir) begin
            reply_st = ((c & 8'h04) != 0) ? 8'h50 : 8'h58;
            reply_rx = (rx_base + rx_n) & 8'hFF; rx_n++;
        end else begin
            reply_st = 8'h28;
        end
        pend = 2;
        if ((c & 8'h10) == 0 && wr_index == fault_idx) begin
            if (fault_kind == 1) reply_st = 8'h38;
            if (fault_kind == 2) begin pend = 0; hang_live = 1; end
        end
        if ((c & 8'h10) != 0 && stop_hang) pend = 0;
        if ((c & 8'h10) == 0) wr_index++;
    endtask

    // per-clock monitor, engine and tick source
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (eng_ctrl_wr) begin
                    if (q_ctrl.size() == 0) begin
                        check(0, "R6", "unexpected engine write", eng_ctrl, 0);
                    end else begin
                        int c, t;
                        string r;
                        c = q_ctrl.pop_front(); t = q_tx.pop_front();
                        void'(q_exp.pop_front()); r = q_req.pop_front();
                        check(eng_ctrl == 8'(c), r, "control value (R10)", eng_ctrl, c);
                        if (t >= 0) check(eng_tx == 8'(t), r, "tx byte", eng_tx, t);
                    end
                    engine_write();
                end
                if (rd_valid) begin
                    if (q_rd.size() == 0) check(0, "R4", "unexpected rd_valid", rd_data, 0);
                    else begin
                        int v;
                        v = q_rd.pop_front();
                        check(rd_data == 8'(v), "R4", "received byte", rd_data, v);
                    end
                end
                if (done) begin
                    check(result == exp_result, "R7", "result word", result, exp_result);
                    check(cmd_ready == 1'b1, "R9", "ready with done", cmd_ready, 1);
                    done_seen = 1;
                end
                if (bump) begin wd_n++; wr_data = 8'((wd_base + wd_n) & 8'hFF); bump = 0; end
                if (wr_take) bump = 1;
                tick_ctr++;
                scl_tick = (tick_ctr % 4 == 0);
                if (scl_tick && !eng_ctrl_wr) begin
                    if (hang_live) polls++;
                    if (pend > 0) begin
                        pend--;
                        if (pend == 0) begin
                            eng_flag = reply_flag; eng_status = 8'(reply_st); eng_rx = 8'(reply_rx);
                        end
                    end
                end
            end
        end
    end

    task automatic add(int c, int t, int e, string r);
        q_ctrl.push_back(c); q_tx.push_back(t); q_exp.push_back(e); q_req.push_back(r);
    endtask

    task automatic build(int kind, int chip, logic [31:0] off, int olen, int len,
                         int fk, int fidx, bit shang);
        int n;
        q_ctrl.delete(); q_tx.delete(); q_exp.delete(); q_req.delete();
        q_rd.delete(); rd_at.delete(); rd_val.delete();
        add(8'h60, -1, 8'h08, "R2");
        if (kind >= 2) begin
            add(8'h40, chip * 2 + 1, 8'h40, "R5");
            add(8'h40, -1, 8'h58, "R5");
        end else begin
            add(8'h40, chip * 2, 8'h18, "R1");
            n = (olen > 4) ? 4 : olen;
            for (int i = 0; i < n; i++) add(8'h40, int'((off >> (8 * i)) & 32'hFF), 8'h28, "R2");
            if (kind == 0) begin
                for (int j = 0; j < len; j++) add(8'h40, (wd_base + j) & 8'hFF, 8'h28, "R2");
            end else begin
                add(8'h60, -1, 8'h10, "R3");
                add(8'h40, chip * 2 + 1, 8'h40, "R1");
                for (int j = 0; j < len; j++) begin
                    rd_at.push_back(q_ctrl.size());
                    rd_val.push_back((rx_base + j) & 8'hFF);
                    if (j == len - 1) add(8'h40, -1, 8'h58, "R4");
                    else              add(8'h44, -1, 8'h50, "R4");
                end
            end
        end
        if (fk != 0) begin
            int c, e;
            c = q_ctrl[fidx]; e = q_exp[fidx];
            if (fk == 1) exp_result = {8'h01, 8'(c | 8'h08), 8'h38, 8'(e)};
            else         exp_result = {8'h02, 8'(c), 8'h00, 8'(e)};
            while (q_ctrl.size() > fidx + 1) begin
                void'(q_ctrl.pop_back()); void'(q_tx.pop_back());
                void'(q_exp.pop_back()); void'(q_req.pop_back());
            end
            foreach (rd_at[i]) if (rd_at[i] < fidx) q_rd.push_back(rd_val[i]);
        end else begin
            foreach (rd_val[i]) q_rd.push_back(rd_val[i]);
            exp_result = shang ? 32'h025000F8 : 32'h0;
        end
        add(8'h50, -1, 8'hF8, "R6");
    endtask

    task automatic run(int kind, int chip, logic [31:0] off, int olen, int len,
                       int fk, int fidx, bit shang, bit poke);
        fault_kind = fk; fault_idx = (fk != 0) ? fidx : -1; stop_hang = shang;
        wr_index = 0; rx_n = 0; wd_n = 0; wr_data = 8'(wd_base); bump = 0;
        polls = 0; hang_live = 0; in_txn = 0; after_start = 0; rd_dir = 0;
        done_seen = 0;
        build(kind, chip, off, olen, len, fk, fidx, shang);
        check(cmd_ready == 1'b1, "R9", "ready before command", cmd_ready, 1);
        cmd_kind = 2'(kind); cmd_chip = 7'(chip); cmd_offset = off;
        cmd_olen = 3'(olen); cmd_len = 16'(len); cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(cmd_ready == 1'b0, "R9", "busy after accept", cmd_ready, 0);
        if (poke) begin
            repeat (10) @(negedge clk);
            cmd_kind = 2'd2; cmd_chip = 7'h11; cmd_valid = 1'b1;   // R9: ignored while busy
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        wait (done_seen);
        repeat (3) @(negedge clk);
        check(q_ctrl.size() == 0, "R6", "all expected writes seen", q_ctrl.size(), 0);
        check(q_rd.size() == 0, "R4", "all expected bytes seen", q_rd.size(), 0);
        if (fk == 2) check(polls == LIMIT, "R8", "polls before timeout", polls, LIMIT);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "R9", "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cmd_ready == 1'b1, "R9", "reset ready", cmd_ready, 1);
        check(eng_ctrl_wr == 1'b0, "R10", "reset no write", eng_ctrl_wr, 0);
        check(done == 1'b0 && result == 32'h0, "R7", "reset result", result, 0);
        // R2 write, two offsets, three payload bytes, busy poke (R9)
        run(0, 7'h50, 32'h0000_1234, 2, 3, 0, 0, 0, 1);
        // R3/R4 read with one offset, three bytes
        run(1, 7'h2A, 32'h0000_00A5, 1, 3, 0, 0, 0, 0);
        // R3 read, no offset, single NAKed byte
        run(1, 7'h0F, 32'h0, 0, 1, 0, 0, 0, 0);
        // R5 clean probe, kind 3 variant too
        run(2, 7'h33, 32'h0, 0, 0, 0, 0, 0, 0);
        run(3, 7'h7F, 32'h0, 0, 0, 0, 0, 0, 0);
        // R5/R7 probe whose address step returns a wrong status
        run(2, 7'h21, 32'h0, 0, 0, 1, 1, 0, 0);
        // R8 timeout on the second offset byte; olen 7 clamps to 4 (R2)
        run(0, 7'h44, 32'hDEAD_BEEF, 7, 1, 2, 3, 0, 0);
        // R6 STOP that never reaches idle
        run(0, 7'h12, 32'h0, 0, 0, 0, 0, 1, 0);
        // R3/R7 wrong status on repeated START
        run(1, 7'h5A, 32'h0000_C3B2, 2, 2, 1, 4, 0, 0);
        // R4 wrong status on an ACKed receive
        run(1, 7'h19, 32'h0, 0, 3, 1, 5, 0, 0);
        summary();
        $finish;
    end
endmodule